// File: doc/BRIEF.md
# Free-Running Sync Generator

This block makes its own horizontal and vertical sync pair from a fixed system clock. It is used when no valid video input is present, for example while an on-screen message is shown. The free-run outputs are meant to be multiplexed onto the sync output pins by logic outside this block. An active-low run input starts the generator. While the generator is stopped, both outputs sit at their inactive level.

The rate-select input picks between two line rates. With the 12 MHz clock that the defaults assume, the fast rate is 62.5 kHz (192 clocks per line) and the slow rate is about 41.7 kHz (288 clocks per line). The frame length is counted in lines and set for roughly 61 Hz at either rate: 1024 lines at the fast rate and 683 lines at the slow rate. The horizontal pulse is 2 µs wide. The vertical pulse is three whole lines wide. Both pulses begin at the first clock of a line.

A rate change waits for the end of the current frame, so a frame never mixes two line lengths. A separate polarity input for each output chooses active-high (1) or active-low (0).

Top module: `sync_freerun_top`

## Requirements
- R1: While reset is asserted (rst_n = 0), and afterwards until the generator is started, both outputs are inactive: hs_out = ~hs_pol and vs_out = ~vs_pol.
- R2: While run_n is 1 at a clock edge, from the next cycle on both outputs stay inactive whatever the other inputs do.
- R3: With the latched rate fast (rate_sel = 1), horizontal pulses start every LINE_FAST clocks.
- R4: With the latched rate slow (rate_sel = 0), horizontal pulses start every LINE_SLOW clocks.
- R5: Vertical pulses start every FRAME_FAST lines at the fast rate and every FRAME_SLOW lines at the slow rate.
- R6: Each horizontal pulse is active for HS_CLKS clocks, beginning at the first clock of a line.
- R7: Each vertical pulse is active for VS_LINES whole lines and begins in the same clock as a horizontal pulse.
- R8: A change of rate_sel while the generator runs takes effect only at the next frame boundary. While stopped, the generator takes rate_sel directly.
- R9: The polarity inputs act combinationally: 1 gives an active-high output, 0 gives an active-low output.
- R10: After run_n is sampled 0 at a clock edge, both outputs become active in the following cycle (first line, first frame).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_n | input | 1 | Active-low generator enable |
| rate_sel | input | 1 | Line rate: 1 fast, 0 slow |
| hs_pol | input | 1 | Horizontal output polarity, 1 active-high |
| vs_pol | input | 1 | Vertical output polarity, 1 active-high |
| hs_out | output | 1 | Free-run horizontal sync |
| vs_out | output | 1 | Free-run vertical sync |

## Verification
The assertions assume that all inputs change only between clock edges and stay steady around each rising edge. The polarity inputs are the exception: because they act combinationally, the output checks read them in the same cycle. The bench drives every input two nanoseconds after a rising edge and samples on the falling edge, so every value is seen as settled. The rate-hold property also assumes that reset is released only while the generator is stopped. The bench keeps run_n high through reset for that reason.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic {RATE_SLOW = 1'b0, RATE_FAST = 1'b1} rate_e;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int cbits(int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Pick the fast or the slow count for a rate.
  function automatic int pick(rate_e r, int fast_v, int slow_v);
    return (r == RATE_FAST) ? fast_v : slow_v;
  endfunction
endpackage

// File: rtl/sfr_line_timer.sv
module sfr_line_timer
  import sfr_pkg::*;
#(
  parameter int LINE_FAST = 192,
  parameter int LINE_SLOW = 288,
  parameter int HW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gen_on,
  input  rate_e         cur_rate,
  output logic [HW-1:0] hcnt,
  output logic          line_end
);
  localparam logic [HW-1:0] LAST_F = HW'(LINE_FAST - 1);
  localparam logic [HW-1:0] LAST_S = HW'(LINE_SLOW - 1);

  logic [HW-1:0] last_clk;
  assign last_clk = (cur_rate == RATE_FAST) ? LAST_F : LAST_S;
  assign line_end = gen_on && (hcnt == last_clk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
    end else if (!gen_on || line_end) begin
      hcnt <= '0;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end
endmodule

// File: rtl/sfr_frame_timer.sv
module sfr_frame_timer
  import sfr_pkg::*;
#(
  parameter int FRAME_FAST = 1024,
  parameter int FRAME_SLOW = 683,
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gen_on,
  input  logic          rate_sel,
  input  logic          line_end,
  output logic [LW-1:0] lcnt,
  output rate_e         cur_rate,
  output logic          frame_end
);
  localparam logic [LW-1:0] LAST_F = LW'(FRAME_FAST - 1);
  localparam logic [LW-1:0] LAST_S = LW'(FRAME_SLOW - 1);

  logic [LW-1:0] last_line;
  assign last_line = (cur_rate == RATE_FAST) ? LAST_F : LAST_S;
  assign frame_end = line_end && (lcnt == last_line);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcnt <= '0;
    end else if (!gen_on || frame_end) begin
      lcnt <= '0;
    end else if (line_end) begin
      lcnt <= lcnt + 1'b1;
    end
  end

  // The rate is latched only while stopped or at a frame boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_rate <= RATE_FAST;
    end else if (!gen_on || frame_end) begin
      cur_rate <= rate_e'(rate_sel);
    end
  end
endmodule

// File: rtl/sfr_shaper.sv
module sfr_shaper #(
  parameter int HS_CLKS = 24,
  parameter int VS_LINES = 3,
  parameter int HW = 9,
  parameter int LW = 10
) (
  input  logic          gen_on,
  input  logic [HW-1:0] hcnt,
  input  logic [LW-1:0] lcnt,
  input  logic          hs_pol,
  input  logic          vs_pol,
  output logic          hs_act,
  output logic          vs_act,
  output logic          hs_out,
  output logic          vs_out
);
  assign hs_act = gen_on && (hcnt < HW'(HS_CLKS));
  assign vs_act = gen_on && (lcnt < LW'(VS_LINES));
  // Output equals the active flag when the polarity is 1, its inverse when 0.
  assign hs_out = hs_act ~^ hs_pol;
  assign vs_out = vs_act ~^ vs_pol;
endmodule

// File: rtl/sync_freerun_top.sv
module sync_freerun_top
  import sfr_pkg::*;
#(
  parameter int LINE_FAST = 192,
  parameter int LINE_SLOW = 288,
  parameter int FRAME_FAST = 1024,
  parameter int FRAME_SLOW = 683,
  parameter int HS_CLKS = 24,
  parameter int VS_LINES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_n,
  input  logic rate_sel,
  input  logic hs_pol,
  input  logic vs_pol,
  output logic hs_out,
  output logic vs_out
);
  localparam int HW = cbits(imax(LINE_FAST, LINE_SLOW));
  localparam int LW = cbits(imax(FRAME_FAST, FRAME_SLOW));

  logic          gen_on;
  logic [HW-1:0] hcnt;
  logic [LW-1:0] lcnt;
  logic          line_end;
  logic          frame_end;
  logic          hs_act;
  logic          vs_act;
  rate_e         cur_rate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gen_on <= 1'b0;
    else        gen_on <= ~run_n;
  end

  sfr_line_timer #(.LINE_FAST(LINE_FAST), .LINE_SLOW(LINE_SLOW), .HW(HW)) u_line (
    .clk(clk), .rst_n(rst_n), .gen_on(gen_on), .cur_rate(cur_rate),
    .hcnt(hcnt), .line_end(line_end)
  );

  sfr_frame_timer #(.FRAME_FAST(FRAME_FAST), .FRAME_SLOW(FRAME_SLOW), .LW(LW)) u_frame (
    .clk(clk), .rst_n(rst_n), .gen_on(gen_on), .rate_sel(rate_sel),
    .line_end(line_end), .lcnt(lcnt), .cur_rate(cur_rate), .frame_end(frame_end)
  );

  sfr_shaper #(.HS_CLKS(HS_CLKS), .VS_LINES(VS_LINES), .HW(HW), .LW(LW)) u_shape (
    .gen_on(gen_on), .hcnt(hcnt), .lcnt(lcnt), .hs_pol(hs_pol), .vs_pol(vs_pol),
    .hs_act(hs_act), .vs_act(vs_act), .hs_out(hs_out), .vs_out(vs_out)
  );
endmodule

// File: rtl/sync_freerun_chk.sv
module sync_freerun_chk
  import sfr_pkg::*;
#(
  parameter int HW = 9,
  parameter int LW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_n,
  input logic          hs_pol,
  input logic          vs_pol,
  input logic          hs_out,
  input logic          vs_out,
  input logic          gen_on,
  input logic [HW-1:0] hcnt,
  input logic [LW-1:0] lcnt,
  input logic          line_end,
  input logic          frame_end,
  input logic          hs_act,
  input logic          vs_act,
  input rate_e         cur_rate
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_on |-> (hs_out == ~hs_pol) && (vs_out == ~vs_pol)); // R2
  AST_STOP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    run_n |=> !gen_on); // R2
  AST_START_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    !run_n |=> gen_on && hcnt == '0 || $past(gen_on)); // R10
  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> hcnt == '0); // R3
  AST_HS_AT_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_act) |-> hcnt == '0); // R6
  AST_VS_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vs_act) |-> hcnt == '0 && lcnt == '0 && hs_act); // R7
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> lcnt == '0); // R5
  AST_RATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    gen_on && !frame_end |=> $stable(cur_rate)); // R8
  AST_POL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    hs_act |-> hs_out == hs_pol); // R9
endmodule

bind sync_freerun_top sync_freerun_chk #(.HW(HW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_n(run_n), .hs_pol(hs_pol), .vs_pol(vs_pol),
  .hs_out(hs_out), .vs_out(vs_out), .gen_on(gen_on), .hcnt(hcnt), .lcnt(lcnt),
  .line_end(line_end), .frame_end(frame_end), .hs_act(hs_act), .vs_act(vs_act),
  .cur_rate(cur_rate)
);

// File: tb/tb_sync_freerun_top.sv
module tb_sync_freerun_top;
  localparam int LF = 12, LS = 18, FF = 10, FS = 7, HSW = 3, VSL = 2;

  logic clk = 1'b0, rst_n = 1'b0, run_n = 1'b1, rate_sel = 1'b1;
  logic hs_pol = 1'b1, vs_pol = 1'b1;
  logic hs_out, vs_out;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  sync_freerun_top #(.LINE_FAST(LF), .LINE_SLOW(LS), .FRAME_FAST(FF),
    .FRAME_SLOW(FS), .HS_CLKS(HSW), .VS_LINES(VSL)) dut (
    .clk(clk), .rst_n(rst_n), .run_n(run_n), .rate_sel(rate_sel),
    .hs_pol(hs_pol), .vs_pol(vs_pol), .hs_out(hs_out), .vs_out(vs_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: running flag, clock-in-line, line-in-frame, rate.
  int m_on = 0, m_h = 0, m_l = 0, m_fast = 1;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_on = 0; m_h = 0; m_l = 0; m_fast = 1;
    end else begin
      int ll, fl, nh, nl, nf;
      ll = m_fast ? LF : LS;
      fl = m_fast ? FF : FS;
      nf = m_fast; nh = 0; nl = 0;
      if (m_on != 0) begin
        if (m_h == ll - 1) begin
          nl = (m_l == fl - 1) ? 0 : m_l + 1;
          if (m_l == fl - 1) nf = rate_sel;
        end else begin
          nh = m_h + 1; nl = m_l;
        end
      end else begin
        nf = rate_sel;
      end
      m_h = nh; m_l = nl; m_fast = nf; m_on = run_n ? 0 : 1;
    end
  end

  bit cmp_en = 1'b0;
  always @(negedge clk) if (cmp_en) begin
    bit eh, ev;
    eh = ((m_on != 0 && m_h < HSW) ? 1'b1 : 1'b0) ~^ hs_pol;
    ev = ((m_on != 0 && m_l < VSL) ? 1'b1 : 1'b0) ~^ vs_pol;
    chk(hs_out == eh, "R6 R9 hs per-cycle", int'(hs_out), int'(eh));
    chk(vs_out == ev, "R7 R9 vs per-cycle", int'(vs_out), int'(ev));
  end

  function automatic bit act(input bit use_v);
    return use_v ? (vs_out == vs_pol) : (hs_out == hs_pol);
  endfunction

  task automatic wait_start(input bit use_v);
    bit p, c;
    p = act(use_v);
    forever begin
      @(negedge clk);
      c = act(use_v);
      if (c && !p) break;
      p = c;
    end
  endtask

  task automatic gap(input bit use_v, output int n);
    bit p, c;
    wait_start(use_v);
    n = 0; p = 1'b1;
    forever begin
      @(negedge clk);
      n++;
      c = act(use_v);
      if (c && !p) break;
      p = c;
    end
  endtask

  task automatic width(input bit use_v, output int n);
    wait_start(use_v);
    n = 1;
    forever begin
      @(negedge clk);
      if (!act(use_v)) break;
      n++;
    end
  endtask

  task automatic drive_at_edge();
    @(posedge clk); #2;
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(hs_out == 1'b0 && vs_out == 1'b0, "R1 outputs inactive in reset",
        int'({hs_out, vs_out}), 0);
    drive_at_edge(); rst_n = 1'b1;
    cmp_en = 1'b1;
    repeat (10) @(negedge clk);
    chk(hs_out == 1'b0 && vs_out == 1'b0, "R1 idle after reset",
        int'({hs_out, vs_out}), 0);
    drive_at_edge(); hs_pol = 1'b0; rate_sel = 1'b0;
    @(negedge clk);
    chk(hs_out == 1'b1, "R2 idle hs at inverse of polarity", int'(hs_out), 1);
    drive_at_edge(); hs_pol = 1'b1; rate_sel = 1'b1;

    // Start: outputs rise one cycle after run_n is sampled low.
    drive_at_edge(); run_n = 1'b0;
    @(negedge clk);
    chk(hs_out == 1'b0, "R10 still idle before sampling edge", int'(hs_out), 0);
    @(negedge clk);
    chk(hs_out == 1'b1 && vs_out == 1'b1, "R10 first line active",
        int'({hs_out, vs_out}), 3);

    gap(1'b0, n);   chk(n == LF, "R3 fast line period", n, LF);
    width(1'b0, n); chk(n == HSW, "R6 hs width", n, HSW);
    width(1'b1, n); chk(n == VSL * LF, "R7 vs width fast", n, VSL * LF);
    gap(1'b1, n);   chk(n == FF * LF, "R5 fast frame period", n, FF * LF);

    // Flip both polarities while running.
    drive_at_edge(); hs_pol = 1'b0; vs_pol = 1'b0;
    wait_start(1'b0);
    chk(hs_out == 1'b0, "R9 active-low hs", int'(hs_out), 0);
    width(1'b1, n); chk(n == VSL * LF, "R9 active-low vs width", n, VSL * LF);

    // Rate change mid-frame: held until the frame ends.
    wait_start(1'b1);
    repeat (3) wait_start(1'b0);
    drive_at_edge(); rate_sel = 1'b0;
    gap(1'b0, n);   chk(n == LF, "R8 rate held mid-frame", n, LF);
    wait_start(1'b1);
    gap(1'b0, n);   chk(n == LS, "R4 slow line period", n, LS);
    gap(1'b1, n);   chk(n == FS * LS, "R5 slow frame period", n, FS * LS);
    width(1'b1, n); chk(n == VSL * LS, "R7 vs width slow", n, VSL * LS);

    // Stop: outputs hold inactive.
    drive_at_edge(); run_n = 1'b1;
    @(negedge clk); @(negedge clk);
    for (int i = 0; i < 30; i++) begin
      chk(hs_out == ~hs_pol && vs_out == ~vs_pol, "R2 stopped outputs inactive",
          int'({hs_out, vs_out}), int'({~hs_pol, ~vs_pol}));
      @(negedge clk);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule